// File: doc/BRIEF.md
# Stepped Digital Volume With Fade

This block scales a stereo stream of 24-bit two's-complement samples by a per-channel gain chosen by an 8-bit code, one code step being 0.5 dB. Software-facing targets are not applied directly. Each channel keeps an applied code. When fading is on, that code walks one step toward its target once every eight sample frames. When fading is off, it jumps to the target at the next frame. Each channel also has a mute bit. Muting forces that channel's output to zero, while its code keeps moving.

The gain is a 12-entry mantissa table covering one 6 dB octave, followed by an arithmetic shift by the octave count. The result is rounded and clamped to the 24-bit range. A sample pair enters with a one-cycle frame strobe. The scaled pair leaves two clock cycles later with its own strobe. The current applied codes are visible on the outputs at all times.

Top module: `vol_fade_core`

## Requirements
- R1: For an applied code c (c ≥ 7), let t = 255 − c, q = t / 12 and r = t mod 12. The output is round(x · M[r] · 2^(4−q) / 65536). M = {65536, 61870, 58409, 55142, 52057, 49145, 46396, 43801, 41350, 39037, 36854, 34792} for r = 0..11. So 0xCF gives exact unity gain and 0xFF gives ×16 (+24 dB).
- R2: An applied code below 0x07 yields a zero output. Code 0x07 is the lowest audible setting (−100 dB).
- R3: Rounding is half-up: floor(v + 0.5) applied to the exact product. Results above 8388607 or below −8388608 are clamped to those limits and never wrap.
- R4: A high mute bit (mute_l, mute_r) sampled with a frame forces that channel's output for the frame to 0. The other channel and both applied codes carry on unchanged.
- R5: With fade_en high, an applied code changes by at most one step per frame, and only on a step frame. A step frame is the eighth frame after the last timer restart, and every eighth frame after that.
- R6: A frame on which fade_en is high and some channel's required direction (up or down) is new restarts the shared step timer. The previous frame's direction for that channel was different, or there was none. No step is taken on that frame.
- R7: A channel whose applied code equals its target takes no step. Its code stays put.
- R8: With fade_en low on a frame, the applied code becomes that frame's target after the frame. The sample of that frame is still scaled with the previous code.
- R9: out_vld rises exactly two clock cycles after frame_vld. Each frame's samples are scaled with the applied code held before that frame's update.
- R10: After synchronous reset both applied codes are 0xCF, out_vld is low and both outputs are zero.
- R11: Left and right codes ramp independently toward their own targets, in opposite directions if required, on the same step frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_vld | input | 1 | One-cycle strobe marking a new sample pair |
| in_l | input | 24 | Left sample, signed |
| in_r | input | 24 | Right sample, signed |
| tgt_l | input | 8 | Left target code |
| tgt_r | input | 8 | Right target code |
| fade_en | input | 1 | 1: ramp one step per eight frames; 0: jump |
| mute_l | input | 1 | Force left output to zero |
| mute_r | input | 1 | Force right output to zero |
| out_vld | output | 1 | Strobe for the scaled pair |
| out_l | output | 24 | Scaled left sample, signed |
| out_r | output | 24 | Scaled right sample, signed |
| cur_l | output | 8 | Left applied code |
| cur_r | output | 8 | Right applied code |

## Verification
The assertions assume that targets, fade_en and the mute bits matter only in cycles where frame_vld is high. They also assume that all inputs are known whenever reset is low. The latency and mute checks assume a frame strobe is one cycle wide. The stimulus raises frame_vld for a single cycle every four cycles and changes targets, fade mode and mutes only between frames. Step timing, reversal restarts and clamping are then predicted frame by frame by a model kept in the bench.

// File: rtl/vol_pkg.sv
package vol_pkg;

  // One octave (about 6 dB) in 0.5 dB steps.
  localparam int STEPS_PER_OCT = 12;
  localparam int MANT_W        = 17;   // holds 1.0 in Q16
  localparam int MANT_FRAC     = 16;
  localparam int MIDX_W        = 4;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'b00,
    DIR_UP   = 2'b01,
    DIR_DOWN = 2'b10
  } step_dir_e;

  // Descending mantissa: entry k is 2^16 * 10^(-k/40), rounded.
  function automatic logic [MANT_W-1:0] mant_lookup(input logic [MIDX_W-1:0] idx);
    logic [MANT_W-1:0] m;
    case (idx)
      4'd0:    m = 17'd65536;
      4'd1:    m = 17'd61870;
      4'd2:    m = 17'd58409;
      4'd3:    m = 17'd55142;
      4'd4:    m = 17'd52057;
      4'd5:    m = 17'd49145;
      4'd6:    m = 17'd46396;
      4'd7:    m = 17'd43801;
      4'd8:    m = 17'd41350;
      4'd9:    m = 17'd39037;
      4'd10:   m = 17'd36854;
      4'd11:   m = 17'd34792;
      default: m = 17'd65536;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/vol_frame_tick.sv
module vol_frame_tick #(
  parameter int FRAMES_PER_STEP = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic frame,
  input  logic restart,
  output logic tick
);
  localparam int CNTW = (FRAMES_PER_STEP > 2) ? $clog2(FRAMES_PER_STEP) : 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(FRAMES_PER_STEP - 1);

  logic [CNTW-1:0] cnt_q;

  // A restart frame is frame zero of a new window and never steps.
  assign tick = frame && !restart && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (frame) begin
      if (restart || cnt_q == LAST) cnt_q <= '0;
      else                          cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/vol_code_ramp.sv
module vol_code_ramp
  import vol_pkg::*;
#(
  parameter int            CW         = 8,
  parameter logic [CW-1:0] RESET_CODE = 8'hCF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame,
  input  logic          fade_en,
  input  logic [CW-1:0] target,
  input  logic          tick,
  output logic [CW-1:0] cur,
  output logic          restart_req
);
  logic [CW-1:0] cur_q;
  step_dir_e     dir, prev_q;

  always_comb begin
    if (target > cur_q)      dir = DIR_UP;
    else if (target < cur_q) dir = DIR_DOWN;
    else                     dir = DIR_HOLD;
  end

  // A movement that begins, or reverses, asks for a fresh eight-frame window.
  assign restart_req = frame && fade_en && (dir != DIR_HOLD) && (dir != prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= RESET_CODE;
      prev_q <= DIR_HOLD;
    end else if (frame) begin
      prev_q <= dir;
      if (!fade_en) begin
        cur_q <= target;
      end else if (tick) begin
        if (dir == DIR_UP)        cur_q <= cur_q + 1'b1;
        else if (dir == DIR_DOWN) cur_q <= cur_q - 1'b1;
      end
    end
  end

  assign cur = cur_q;

endmodule

// File: rtl/vol_gain_lane.sv
module vol_gain_lane
  import vol_pkg::*;
#(
  parameter int DW         = 24,
  parameter int CW         = 8,
  parameter int UNITY_CODE = 207,
  parameter int MIN_CODE   = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] din,
  input  logic [CW-1:0]        code,
  input  logic                 mute,
  output logic                 vld,
  output logic signed [DW-1:0] dout
);
  localparam int FULL    = (1 << CW) - 1;
  localparam int TOP_OCT = (FULL - UNITY_CODE) / STEPS_PER_OCT;
  localparam int SH_MAX  = MANT_FRAC - TOP_OCT + FULL / STEPS_PER_OCT;
  localparam int SHW     = $clog2(SH_MAX + 1);
  localparam int PW      = DW + MANT_W + 1;
  localparam int AW      = PW + 1;

  localparam logic [CW-1:0]        FULL_C = CW'(FULL);
  localparam logic [CW-1:0]        STEP_C = CW'(STEPS_PER_OCT);
  localparam logic [CW-1:0]        MIN_C  = CW'(MIN_CODE);
  localparam logic [SHW-1:0]       SH_OFS = SHW'(MANT_FRAC - TOP_OCT);
  localparam logic signed [AW-1:0] SAT_HI = AW'((1 << (DW - 1)) - 1);
  localparam logic signed [AW-1:0] SAT_LO = ~SAT_HI;

  // Stage 1: split the attenuation into octave and mantissa, multiply.
  logic [CW-1:0]          atten;
  logic [MIDX_W-1:0]      midx;
  logic [SHW-1:0]         sh_c;
  logic [MANT_W-1:0]      mant;
  logic signed [PW-1:0]   din_x, mant_x, prod_c;

  assign atten  = FULL_C - code;
  assign midx   = MIDX_W'(atten % STEP_C);
  assign sh_c   = SH_OFS + SHW'(atten / STEP_C);
  assign mant   = mant_lookup(midx);
  assign din_x  = din;
  assign mant_x = $signed({{(PW - MANT_W){1'b0}}, mant});
  assign prod_c = din_x * mant_x;

  logic signed [PW-1:0] prod_q;
  logic [SHW-1:0]       sh_q;
  logic                 kill_q, v1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      sh_q   <= SH_OFS;
      kill_q <= 1'b1;
      v1_q   <= 1'b0;
    end else begin
      v1_q <= en;
      if (en) begin
        prod_q <= prod_c;
        sh_q   <= sh_c;
        kill_q <= mute || (code < MIN_C);
      end
    end
  end

  // Stage 2: round half-up, shift, clamp.
  logic signed [AW-1:0] half, sum, shifted, clamped;

  assign half    = AW'(1) <<< (sh_q - 1'b1);
  assign sum     = AW'(prod_q) + half;
  assign shifted = sum >>> sh_q;

  always_comb begin
    if (shifted > SAT_HI)      clamped = SAT_HI;
    else if (shifted < SAT_LO) clamped = SAT_LO;
    else                       clamped = shifted;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= 1'b0;
      dout <= '0;
    end else begin
      vld <= v1_q;
      if (v1_q) dout <= kill_q ? '0 : clamped[DW-1:0];
    end
  end

endmodule

// File: rtl/vol_fade_core.sv
module vol_fade_core #(
  parameter int DW              = 24,
  parameter int CW              = 8,
  parameter int UNITY_CODE      = 207,
  parameter int MIN_CODE        = 7,
  parameter int FRAMES_PER_STEP = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_vld,
  input  logic signed [DW-1:0] in_l,
  input  logic signed [DW-1:0] in_r,
  input  logic [CW-1:0]        tgt_l,
  input  logic [CW-1:0]        tgt_r,
  input  logic                 fade_en,
  input  logic                 mute_l,
  input  logic                 mute_r,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_l,
  output logic signed [DW-1:0] out_r,
  output logic [CW-1:0]        cur_l,
  output logic [CW-1:0]        cur_r
);
  localparam int NCH = 2;

  logic signed [DW-1:0] din  [NCH];
  logic signed [DW-1:0] dout [NCH];
  logic [CW-1:0]        tgt  [NCH];
  logic [CW-1:0]        cur  [NCH];
  logic [NCH-1:0]       mute, rs_req, lane_vld;
  logic                 tick;

  assign din[0] = in_l;
  assign din[1] = in_r;
  assign tgt[0] = tgt_l;
  assign tgt[1] = tgt_r;
  assign mute   = {mute_r, mute_l};

  vol_frame_tick #(.FRAMES_PER_STEP(FRAMES_PER_STEP)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .frame   (frame_vld),
    .restart (|rs_req),
    .tick    (tick)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    vol_code_ramp #(.CW(CW), .RESET_CODE(CW'(UNITY_CODE))) u_ramp (
      .clk         (clk),
      .rst         (rst),
      .frame       (frame_vld),
      .fade_en     (fade_en),
      .target      (tgt[ch]),
      .tick        (tick),
      .cur         (cur[ch]),
      .restart_req (rs_req[ch])
    );

    vol_gain_lane #(.DW(DW), .CW(CW), .UNITY_CODE(UNITY_CODE), .MIN_CODE(MIN_CODE)) u_lane (
      .clk  (clk),
      .rst  (rst),
      .en   (frame_vld),
      .din  (din[ch]),
      .code (cur[ch]),
      .mute (mute[ch]),
      .vld  (lane_vld[ch]),
      .dout (dout[ch])
    );
  end

  assign out_vld = &lane_vld;
  assign out_l   = dout[0];
  assign out_r   = dout[1];
  assign cur_l   = cur[0];
  assign cur_r   = cur[1];

endmodule

// File: rtl/vol_fade_core_chk.sv
module vol_fade_core_chk #(
  parameter int DW       = 24,
  parameter int CW       = 8,
  parameter int MIN_CODE = 7
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 frame_vld,
  input logic [CW-1:0]        tgt_l,
  input logic [CW-1:0]        tgt_r,
  input logic                 fade_en,
  input logic                 mute_l,
  input logic                 mute_r,
  input logic                 out_vld,
  input logic signed [DW-1:0] out_l,
  input logic signed [DW-1:0] out_r,
  input logic [CW-1:0]        cur_l,
  input logic [CW-1:0]        cur_r
);
  localparam logic [CW-1:0] MIN_C = CW'(MIN_CODE);

  a_r9_latency: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(frame_vld, 2));

  a_r5_idle_hold_l: assert property (@(posedge clk) disable iff (rst)
    !frame_vld |=> $stable(cur_l));

  a_r5_single_step_l: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && fade_en) |=>
      (cur_l == $past(cur_l) || cur_l == $past(cur_l) + 1'b1 || cur_l == $past(cur_l) - 1'b1));

  a_r5_single_step_r: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && fade_en) |=>
      (cur_r == $past(cur_r) || cur_r == $past(cur_r) + 1'b1 || cur_r == $past(cur_r) - 1'b1));

  a_r7_parked_l: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && fade_en && cur_l == tgt_l) |=> (cur_l == $past(cur_l)));

  a_r8_jump_r: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && !fade_en) |=> (cur_r == $past(tgt_r)));

  a_r4_mute_l: assert property (@(posedge clk) disable iff (rst)
    (out_vld && $past(mute_l, 2)) |-> (out_l == '0));

  a_r4_mute_r: assert property (@(posedge clk) disable iff (rst)
    (out_vld && $past(mute_r, 2)) |-> (out_r == '0));

  a_r2_low_code_l: assert property (@(posedge clk) disable iff (rst)
    (out_vld && $past(cur_l, 2) < MIN_C) |-> (out_l == '0));

endmodule

bind vol_fade_core vol_fade_core_chk u_chk (.*);

// File: tb/tb_vol_fade_core.sv
module tb_vol_fade_core;
  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic               rst = 1'b1;
  logic               frame_vld = 1'b0;
  logic signed [23:0] in_l = '0, in_r = '0;
  logic [7:0]         tgt_l = 8'hCF, tgt_r = 8'hCF;
  logic               fade_en = 1'b0, mute_l = 1'b0, mute_r = 1'b0;
  logic               out_vld;
  logic signed [23:0] out_l, out_r;
  logic [7:0]         cur_l, cur_r;

  vol_fade_core dut (.*);

  localparam int MANT [12] = '{65536, 61870, 58409, 55142, 52057, 49145,
                               46396, 43801, 41350, 39037, 36854, 34792};

  int n_chk = 0, n_bad = 0;

  longint q_l[$], q_r[$];
  int     q_cl[$], q_cr[$];
  string  q_tag[$];

  // Frame-level model state
  int m_cur[2] = '{207, 207};
  int m_prev[2] = '{0, 0};
  int m_cnt = 0;

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic longint model_out(input longint s, input int code, input bit m);
    longint p, y;
    int t, q, r, sh;
    if (m || code < 7) return 0;
    t  = 255 - code;
    q  = t / 12;
    r  = t % 12;
    p  = s * MANT[r];
    sh = 12 + q;
    y  = (p + (longint'(1) <<< (sh - 1))) >>> sh;
    if (y > 8388607)  y = 8388607;
    if (y < -8388608) y = -8388608;
    return y;
  endfunction

  task automatic drive_frame(input int sl, input int sr, input int tl, input int tr,
                             input bit fd, input bit ml, input bit mr, input string tag);
    int  dir[2];
    int  tg[2];
    bit  rs;
    bit  tk;
    tg[0] = tl;
    tg[1] = tr;
    q_l.push_back(model_out(sl, m_cur[0], ml));
    q_r.push_back(model_out(sr, m_cur[1], mr));
    rs = 1'b0;
    for (int c = 0; c < 2; c++) begin
      dir[c] = (tg[c] > m_cur[c]) ? 1 : ((tg[c] < m_cur[c]) ? -1 : 0);
      if (fd && dir[c] != 0 && dir[c] != m_prev[c]) rs = 1'b1;
    end
    tk = 1'b0;
    if (rs) m_cnt = 0;
    else if (m_cnt == 7) begin tk = 1'b1; m_cnt = 0; end
    else m_cnt++;
    for (int c = 0; c < 2; c++) begin
      m_prev[c] = dir[c];
      if (!fd) m_cur[c] = tg[c];
      else if (tk) m_cur[c] = m_cur[c] + dir[c];
    end
    q_cl.push_back(m_cur[0]);
    q_cr.push_back(m_cur[1]);
    q_tag.push_back(tag);

    in_l = 24'(sl); in_r = 24'(sr);
    tgt_l = 8'(tl); tgt_r = 8'(tr);
    fade_en = fd; mute_l = ml; mute_r = mr;
    frame_vld = 1'b1;
    @(negedge clk);
    frame_vld = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Monitor: pop the oldest expectation whenever a result appears.
  always @(negedge clk) begin
    if (!rst && out_vld) begin
      if (q_tag.size() == 0) begin
        check("R9", "unexpected out_vld", 1, 0);
      end else begin
        string tg;
        tg = q_tag.pop_front();
        check(tg, "out_l", longint'(out_l), q_l.pop_front());
        check(tg, "out_r", longint'(out_r), q_r.pop_front());
        check(tg, "cur_l", longint'(cur_l), longint'(q_cl.pop_front()));
        check(tg, "cur_r", longint'(cur_r), longint'(q_cr.pop_front()));
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check("WDOG", "timeout", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int codes[6];
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10", "out_vld", longint'(out_vld), 0);
    check("R10", "out_l", longint'(out_l), 0);
    check("R10", "out_r", longint'(out_r), 0);
    check("R10", "cur_l", longint'(cur_l), 207);
    check("R10", "cur_r", longint'(cur_r), 207);

    // R1 / R9 unity gain at 0xCF
    drive_frame(123456, -7654321, 207, 207, 0, 0, 0, "R1");
    drive_frame(8388607, -8388608, 207, 207, 0, 0, 0, "R1");
    drive_frame(-1, 1, 207, 207, 0, 0, 0, "R9");

    // R8 jump to +24 dB; first frame still at unity
    drive_frame(1000, -1000, 255, 255, 0, 0, 0, "R8");
    drive_frame(100000, -250000, 255, 255, 0, 0, 0, "R1");
    drive_frame(4194304, -4194305, 255, 255, 0, 0, 0, "R3");
    drive_frame(8388607, -8388608, 255, 255, 0, 0, 0, "R3");

    // R3 half-up rounding at exactly -6 dB (0xC3)
    drive_frame(0, 0, 195, 195, 0, 0, 0, "R8");
    drive_frame(3, -3, 195, 195, 0, 0, 0, "R3");
    drive_frame(5, -5, 195, 195, 0, 0, 0, "R3");
    drive_frame(1, -1, 195, 195, 0, 0, 0, "R3");

    // R1 code sweep
    codes = '{200, 176, 144, 64, 16, 229};
    foreach (codes[i]) begin
      drive_frame(0, 0, codes[i], codes[i], 0, 0, 0, "R8");
      drive_frame(5000000, -3333333, codes[i], codes[i], 0, 0, 0, "R1");
      drive_frame(-777777, 2468013, codes[i], codes[i], 0, 0, 0, "R1");
    end

    // R2 low codes
    drive_frame(0, 0, 7, 6, 0, 0, 0, "R2");
    drive_frame(8388607, -8388608, 7, 6, 0, 0, 0, "R2");
    drive_frame(0, 0, 0, 8, 0, 0, 0, "R2");
    drive_frame(-8388608, 8388607, 0, 8, 0, 0, 0, "R2");

    // R4 mute per channel
    drive_frame(0, 0, 207, 207, 0, 0, 0, "R4");
    drive_frame(3000000, 3000000, 207, 207, 0, 1, 0, "R4");
    drive_frame(-3000000, -3000000, 207, 207, 0, 0, 1, "R4");
    for (int i = 0; i < 20; i++)
      drive_frame(2000000 + i * 1111, -1500000 - i * 777, 210, 204, 1, 1, i[0], "R4");

    // R5 / R7 fade up and park
    drive_frame(0, 0, 207, 207, 0, 0, 0, "R8");
    for (int i = 0; i < 40; i++)
      drive_frame(1200000 + i * 313, -900000 + i * 211, 211, 207, 1, 0, 0, (i < 33) ? "R5" : "R7");

    // R6 reversal mid-ramp
    for (int i = 0; i < 12; i++)
      drive_frame(700000, -700000, 224, 224, 1, 0, 0, "R6");
    for (int i = 0; i < 20; i++)
      drive_frame(700000 - i, -700000 + i, 192, 192, 1, 0, 0, "R6");

    // R11 opposite directions on shared step frames
    for (int i = 0; i < 40; i++)
      drive_frame(1500000 + i * 97, 1500000 - i * 89, 216, 184, 1, 0, 0, "R11");

    repeat (6) @(negedge clk);
    check("R9", "pending results", longint'(q_tag.size()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule